// File: doc/BRIEF.md
# Address Security Attribution Unit

This block decides, for any 32-bit bus address, whether that address belongs to the Secure or the Non-Secure world. Two sources feed the decision. One is a fixed attribution taken from address bit 28: any address with that bit set is Secure, and any address with it clear is Non-Secure by this source alone. The other is a programmable attribution built from a small bank of address regions and a control register. The final answer is the more secure of the two, so the fixed map can never be weakened by programming.

Secure software programs the unit through a single-cycle write port. A write that arrives while the requester is in the Non-Secure state changes nothing, and the unit flags it on an error output on the following cycle. The lookup path is purely combinational. It reads the register state and returns, in the same cycle, the security attribute, a region-hit flag, the matched region index and a flag for a Secure region that may be called from Non-Secure code. No handshake is used on either side. Each write is taken on the clock edge where `wr_en` is high, and the lookup follows its address input with no back-pressure.

Top module: `sec_attr_unit`

## Requirements
- R1: When lookup address bit 28 is 1, `lk_secure` is 1, whatever the register state.
- R2: After reset the control register is 0. With that state every address is reported Secure, with `lk_hit`, `lk_nsc` and `lk_region` all 0.
- R3: Control register bit 0 enables the programmable unit and bit 1 is the all-non-secure bit. While bit 0 is 0, the programmable result is Non-Secure if bit 1 is 1 and Secure if bit 1 is 0.
- R4: While the unit is enabled and no region matches, the programmable result is Non-Secure if the all-non-secure bit is 1 and Secure otherwise. `lk_hit` is 0 in this case.
- R5: Region n matches when its enable bit is set and base ≤ address[31:5] ≤ limit, both bounds inclusive at 32-byte granularity. With exactly one match, `lk_hit` is 1 and `lk_region` equals n.
- R6: A single matched region with its callable bit 0 gives a Non-Secure programmable result and `lk_nsc` 0. With its callable bit 1 it gives a Secure result and `lk_nsc` 1.
- R7: When two or more regions match, `lk_secure` is 1 and `lk_hit`, `lk_nsc` and `lk_region` are all 0.
- R8: While the unit is disabled, regions are not consulted: `lk_hit` and `lk_nsc` stay 0.
- R9: Writes take effect at the clock edge that samples `wr_en`. The write map is: `wr_addr` 0x00 is the control register; 0x08+n is the base of region n (data[31:5]); 0x10+n is the limit of region n (data[31:5] for the limit, data[0] for the region enable, data[1] for the callable bit). Any other offset is ignored.
- R10: A write with `wr_nonsec` 1 leaves all registers unchanged, and `wr_err` is 1 for exactly the cycle after it. `wr_err` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_nonsec | input | 1 | Requester is in the Non-Secure state |
| wr_addr | input | 5 | Register offset |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Rejected Non-Secure write in the previous cycle |
| lk_addr | input | 32 | Address to classify |
| lk_secure | output | 1 | 1 = Secure, 0 = Non-Secure |
| lk_nsc | output | 1 | Matched region is Secure and callable from Non-Secure code |
| lk_hit | output | 1 | Exactly one enabled region matched |
| lk_region | output | 3 | Index of the matched region |

## Verification
Several rules are checked by assertions on every cycle. Bit 28 always forces a Secure result. A reported hit always has exactly one matching region. Multiple matches always resolve to Secure with no hit. A disabled unit never reports a hit. A Non-Secure write always leaves the register bank untouched and raises the error flag. Other behaviour depends on the sequence of writes and lookups, and only the bench scenarios can show it. This covers inclusive granule boundaries, region index encoding, the way the all-non-secure bit combines with the enable bit, and the one-cycle timing of writes.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int SAU_ADDR_W    = 32;
  localparam int SAU_GRAN_LOG2 = 5;
  localparam int SAU_PAGE_W    = SAU_ADDR_W - SAU_GRAN_LOG2;

  typedef struct packed {
    logic [SAU_PAGE_W-1:0] base;
    logic [SAU_PAGE_W-1:0] limit;
    logic                  en;
    logic                  nsc;
  } region_t;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'b00,
    SEL_BASE  = 2'b01,
    SEL_LIMIT = 2'b10,
    SEL_NONE  = 2'b11
  } wr_sel_e;
endpackage

// File: rtl/sau_regs.sv
module sau_regs
  import sau_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3,
  parameter int WADDR_W     = IDX_W + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_nonsec,
  input  logic [WADDR_W-1:0]            wr_addr,
  input  logic [SAU_ADDR_W-1:0]         wr_data,
  output logic                          wr_err,
  output logic                          ctrl_en,
  output logic                          ctrl_allns,
  output region_t [NUM_REGIONS-1:0]     regions
);
  wr_sel_e          sel;
  logic [IDX_W-1:0] idx;
  logic             wr_ok;
  logic [1:0]       ctrl_q;

  assign sel   = wr_sel_e'(wr_addr[WADDR_W-1 -: 2]);
  assign idx   = wr_addr[IDX_W-1:0];
  assign wr_ok = wr_en && !wr_nonsec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= wr_en && wr_nonsec;
      if (wr_ok && sel == SEL_CTRL && idx == '0)
        ctrl_q <= wr_data[1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regions[g] <= '0;
      end else if (wr_ok && idx == IDX_W'(g)) begin
        if (sel == SEL_BASE)
          regions[g].base <= wr_data[SAU_ADDR_W-1:SAU_GRAN_LOG2];
        if (sel == SEL_LIMIT) begin
          regions[g].limit <= wr_data[SAU_ADDR_W-1:SAU_GRAN_LOG2];
          regions[g].en    <= wr_data[0];
          regions[g].nsc   <= wr_data[1];
        end
      end
    end
  end

  assign ctrl_en    = ctrl_q[0];
  assign ctrl_allns = ctrl_q[1];

  assert_nonsec_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_nonsec) |=> ($stable(ctrl_q) && $stable(regions) && wr_err));
  assert_err_only_after_nonsec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_nonsec) |=> !wr_err);
endmodule

// File: rtl/sau_region_match.sv
module sau_region_match
  import sau_pkg::*;
(
  input  logic [SAU_PAGE_W-1:0] page,
  input  region_t               region,
  output logic                  match
);
  logic above_base;
  logic below_limit;

  assign above_base  = page >= region.base;
  assign below_limit = page <= region.limit;
  assign match       = region.en && above_base && below_limit;
endmodule

// File: rtl/sau_resolve.sv
module sau_resolve #(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fixed_secure,
  input  logic                   ctrl_en,
  input  logic                   ctrl_allns,
  input  logic [NUM_REGIONS-1:0] match_vec,
  input  logic [NUM_REGIONS-1:0] nsc_vec,
  output logic                   secure,
  output logic                   nsc,
  output logic                   hit,
  output logic [IDX_W-1:0]       region
);
  logic [NUM_REGIONS-1:0] live;
  logic [IDX_W-1:0]       first_idx;
  logic                   any_hit;
  logic                   multi;
  logic                   prog_secure;

  assign live = ctrl_en ? match_vec : '0;

  always_comb begin
    first_idx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--)
      if (live[i]) first_idx = IDX_W'(i);
  end

  assign any_hit = |live;
  assign multi   = (live & (live - 1'b1)) != '0;

  always_comb begin
    if (!ctrl_en || !any_hit) prog_secure = !ctrl_allns;
    else if (multi)           prog_secure = 1'b1;
    else                      prog_secure = nsc_vec[first_idx];
  end

  assign hit    = any_hit && !multi;
  assign region = hit ? first_idx : '0;
  assign nsc    = hit && nsc_vec[first_idx];
  assign secure = fixed_secure || prog_secure;

  assert_fixed_secure_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_secure |-> secure);
  assert_hit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(match_vec) == 1));
  assert_overlap_secure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && $countones(match_vec) > 1) |-> (secure && !hit && !nsc));
  assert_disabled_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (!hit && !nsc));
endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
  import sau_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int FIXED_BIT   = 28,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int WADDR_W    = IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_nonsec,
  input  logic [WADDR_W-1:0]    wr_addr,
  input  logic [SAU_ADDR_W-1:0] wr_data,
  output logic                  wr_err,
  input  logic [SAU_ADDR_W-1:0] lk_addr,
  output logic                  lk_secure,
  output logic                  lk_nsc,
  output logic                  lk_hit,
  output logic [IDX_W-1:0]      lk_region
);
  logic                         ctrl_en;
  logic                         ctrl_allns;
  region_t [NUM_REGIONS-1:0]    regions;
  logic [NUM_REGIONS-1:0]       match_vec;
  logic [NUM_REGIONS-1:0]       nsc_vec;

  sau_regs #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W), .WADDR_W(WADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_nonsec(wr_nonsec),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .ctrl_en(ctrl_en), .ctrl_allns(ctrl_allns), .regions(regions)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    sau_region_match u_match (
      .page(lk_addr[SAU_ADDR_W-1:SAU_GRAN_LOG2]),
      .region(regions[g]),
      .match(match_vec[g])
    );
    assign nsc_vec[g] = regions[g].nsc;
  end

  sau_resolve #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_resolve (
    .clk(clk), .rst_n(rst_n),
    .fixed_secure(lk_addr[FIXED_BIT]),
    .ctrl_en(ctrl_en), .ctrl_allns(ctrl_allns),
    .match_vec(match_vec), .nsc_vec(nsc_vec),
    .secure(lk_secure), .nsc(lk_nsc), .hit(lk_hit), .region(lk_region)
  );
endmodule

// File: tb/sec_attr_unit_test.sv
module sec_attr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_nonsec = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err;
  logic [31:0] lk_addr = '0;
  logic        lk_secure, lk_nsc, lk_hit;
  logic [2:0]  lk_region;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R2";
  logic done = 1'b0;

  // behavioural reference state
  logic [1:0]  m_ctrl;
  logic [26:0] m_base [8];
  logic [26:0] m_limit [8];
  logic        m_en [8];
  logic        m_nsc [8];
  logic        m_err;

  always #4 clk = ~clk;

  sec_attr_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_nonsec(wr_nonsec),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .lk_addr(lk_addr), .lk_secure(lk_secure), .lk_nsc(lk_nsc),
    .lk_hit(lk_hit), .lk_region(lk_region)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 2'b00;
      m_err  = 1'b0;
      for (int i = 0; i < 8; i++) begin
        m_base[i] = '0; m_limit[i] = '0; m_en[i] = 1'b0; m_nsc[i] = 1'b0;
      end
    end else begin
      m_err = wr_en && wr_nonsec;
      if (wr_en && !wr_nonsec) begin
        if (wr_addr == 5'h00) m_ctrl = wr_data[1:0];
        else if (wr_addr >= 5'h08 && wr_addr < 5'h10) m_base[wr_addr - 5'h08] = wr_data[31:5];
        else if (wr_addr >= 5'h10 && wr_addr < 5'h18) begin
          m_limit[wr_addr - 5'h10] = wr_data[31:5];
          m_en[wr_addr - 5'h10]    = wr_data[0];
          m_nsc[wr_addr - 5'h10]   = wr_data[1];
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int nmatch;
      int idx;
      logic e_sec, e_nsc, e_hit, prog;
      logic [2:0] e_reg;
      nmatch = 0; idx = 0;
      if (m_ctrl[0])
        for (int i = 7; i >= 0; i--)
          if (m_en[i] && lk_addr[31:5] >= m_base[i] && lk_addr[31:5] <= m_limit[i]) begin
            nmatch++; idx = i;
          end
      e_hit = (nmatch == 1);
      e_reg = e_hit ? 3'(idx) : 3'd0;
      e_nsc = e_hit && m_nsc[idx];
      if (nmatch == 0) prog = !m_ctrl[1];
      else if (nmatch > 1) prog = 1'b1;
      else prog = m_nsc[idx];
      e_sec = lk_addr[28] | prog;
      checks++;
      if ({lk_secure, lk_nsc, lk_hit, lk_region, wr_err} !== {e_sec, e_nsc, e_hit, e_reg, m_err}) begin
        errors++;
        $display("FAIL %s addr=%h actual sec=%b nsc=%b hit=%b reg=%0d err=%b expected sec=%b nsc=%b hit=%b reg=%0d err=%b",
                 cur_req, lk_addr, lk_secure, lk_nsc, lk_hit, lk_region, wr_err,
                 e_sec, e_nsc, e_hit, e_reg, m_err);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic ns);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_nonsec = ns;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_nonsec = 1'b0;
  endtask

  task automatic look(input logic [31:0] a);
    @(posedge clk); #1;
    lk_addr = a;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R2";
    look(32'h0010_0400); look(32'h1010_0400); look(32'h0000_0000); look(32'hFFFF_FFE0);
    // R8: region programmed while disabled is ignored
    cur_req = "R8";
    wr(5'h08, 32'h0010_0000, 1'b0);
    wr(5'h10, 32'h001F_FFE0 | 32'h1, 1'b0);
    look(32'h0010_0400); look(32'h0010_0000);
    cur_req = "R3";
    wr(5'h00, 32'h2, 1'b0);
    look(32'h0010_0400); look(32'h1010_0400); look(32'h0FFF_FFFF);
    cur_req = "R4";
    wr(5'h00, 32'h1, 1'b0);
    look(32'h0050_0000); look(32'h1050_0000);
    wr(5'h00, 32'h3, 1'b0);
    look(32'h0050_0000); look(32'h1050_0000);
    cur_req = "R5";
    look(32'h0010_0000); look(32'h0010_001F); look(32'h000F_FFFF);
    look(32'h001F_FFFF); look(32'h0020_0000); look(32'h001F_FFE0);
    cur_req = "R6";
    wr(5'h0B, 32'h0030_0000, 1'b0);
    wr(5'h13, 32'h0030_00E0 | 32'h3, 1'b0);
    look(32'h0030_0000); look(32'h0030_00FF); look(32'h0030_0100);
    cur_req = "R1";
    wr(5'h0D, 32'h1000_0000, 1'b0);
    wr(5'h15, 32'h1000_FFE0 | 32'h1, 1'b0);
    look(32'h1000_0040); look(32'h1001_0000);
    cur_req = "R7";
    wr(5'h09, 32'h0018_0000, 1'b0);
    wr(5'h11, 32'h0025_0000 | 32'h1, 1'b0);
    look(32'h0019_0000); look(32'h0022_0000); look(32'h0010_0000);
    cur_req = "R10";
    wr(5'h00, 32'h0, 1'b1);
    look(32'h0022_0000);
    wr(5'h11, 32'h0, 1'b1);
    wr(5'h11, 32'h0, 1'b1);
    look(32'h0019_0000);
    cur_req = "R9";
    wr(5'h1F, 32'hFFFF_FFFF, 1'b0);
    wr(5'h07, 32'h0000_0003, 1'b0);
    look(32'h0050_0000); look(32'h0019_0000);
    for (int k = 0; k < 600; k++) begin
      if (k % 7 == 0)
        wr(5'($urandom_range(0, 31)), $urandom, 1'($urandom_range(0, 1)));
      else
        look({$urandom_range(0, 1) ? 4'h1 : 4'h0, 3'b000, 1'($urandom_range(0, 1)), 24'($urandom_range(0, 32'h3F_FFFF))});
    end
    @(posedge clk); #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule